// File: doc/BRIEF.md
# Multi-Cycle 8-bit Accumulator Processor Core

This core runs a small subset of an 8-bit accumulator instruction set. Its programmer-visible state is two 8-bit accumulators A and B, which also act together as a 16-bit pair D with A as the high byte. It also has a 16-bit index register X, an 8-bit page register, a 16-bit program counter and the N, Z and C flags. A single byte-wide synchronous memory port carries every access. The core drives the address, write data and write enable from registers. The memory returns read data one clock after the edge that captures the address.

The opcode byte decides how many operand bytes follow, and the core fetches them one at a time. Operands can be immediate values, 8-bit page offsets placed under the page register, or full 16-bit addresses. The core also handles conditional relative branches on the flags, an absolute jump, and a register transfer into the page register. A software-interrupt opcode stops the core and raises `halted`. Any opcode outside the subset also stops the core, and raises `illegal` as well as `halted`.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high, and after it falls, the core holds mem_addr=0x0000, mem_we=0, halted=0 and illegal=0. PC, A, B, X, page and all flags are zero, and the first fetch reads address 0x0000.
- R2: Operand bytes are fetched one per access, and their count follows the opcode. An instruction with no operand takes 3 clocks. One with a 1-byte operand (immediate or branch) takes 6 clocks. One with a 16-bit address that stores a single byte takes 8 clocks.
- R3: 0x86/0x96/0xB6 load A (immediate / page / extended). 0x97/0xB7 store A and 0xD7 stores B. A page address is {page register, offset byte}.
- R4: 0x8B/0x9B/0xBB add to A, 0x89/0x99/0xB9 add with carry, 0x84/0x94/0xB4 AND, and 0x8A/0x9A/0xBA OR. N is set from bit 7 of the result and Z when the result is zero. Add and add-with-carry set C to the carry out, while AND, OR and loads leave C unchanged.
- R5: 0x81/0x91/0xB1 compare A with the operand. A is left unchanged, N and Z follow A minus the operand, and C=1 when the operand is larger than A (unsigned borrow).
- R6: 0xCC/0xFC load D and 0x8E/0xBE load X, with the high byte first (immediate) or from EA and the low byte from EA+1. 0xFD stores A at EA and B at EA+1. A 16-bit load sets N from bit 15 and Z when all 16 bits are zero.
- R7: 0x27 branches if Z=1, 0x26 if Z=0 and 0x2B if N=1. The 8-bit two's-complement offset is added to the address that follows the offset byte.
- R8: 0x7E loads the PC with the following two bytes, high byte first.
- R9: 0x4F clears A and 0x5F clears B. Each sets N=0 and Z=1 and leaves C unchanged.
- R10: 0x1F followed by 0x8B copies A into the page register. 0x1F followed by any other byte is treated as an unsupported opcode.
- R11: 0x3F raises `halted` with `illegal` low. After that, no write is issued, mem_addr does not change, and no register changes until reset.
- R12: Any opcode not listed above raises both `halted` and `illegal` three clocks after its fetch starts, and both outputs stay high until reset.
- R13: 0x12 changes nothing except that the PC moves past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Registered memory address |
| mem_wdata | output | 8 | Registered write data |
| mem_we | output | 1 | Registered write enable, one clock per byte written |
| mem_rdata | input | 8 | Read data, valid one clock after the address edge |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an unsupported opcode |

## Verification
Every memory access costs two clocks: one edge registers the address and the memory answers at the next edge. This gives fixed totals of 3, 6 and 8 clocks for the instruction shapes in R2, and one more memory round trip for each data byte that is read. The bench counts rising edges from the release of reset, samples `halted` at each falling edge, and compares the count at which it first rises with totals worked out by hand from those figures. Data results are checked in the bench memory only after the core has halted, which is well past the edge that carries the final write.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam logic [7:0] TFR_A_TO_PAGE = 8'h8B;

  typedef enum logic [3:0] {
    S_IREQ, S_IWAIT, S_IDEC, S_OWAIT, S_OCAP,
    S_EXEC, S_MWAIT, S_MCAP, S_ST2, S_HALT
  } cpu_state_e;

  typedef enum logic [1:0] {M_INH, M_IMM, M_PAGE, M_EXT} amode_e;

  typedef enum logic [4:0] {
    OP_LDA, OP_STA, OP_STB, OP_ADD, OP_ADC, OP_AND, OP_OR, OP_CMP,
    OP_LDD, OP_STD, OP_LDX, OP_CLRA, OP_CLRB, OP_NOP, OP_SWI,
    OP_BEQ, OP_BNE, OP_BMI, OP_JMP, OP_TFR
  } op_e;

  typedef enum logic [2:0] {ALU_LD, ALU_ADD, ALU_ADC, ALU_AND, ALU_OR, ALU_CMP} alu_e;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [7:0] opcode,
  output logic       valid,
  output op_e        op,
  output amode_e     mode,
  output logic       wide,
  output logic [1:0] nbytes
);
  logic [3:0] hi, lo;
  assign hi = opcode[7:4];
  assign lo = opcode[3:0];

  always_comb begin
    valid = 1'b1;
    op    = OP_NOP;
    mode  = M_INH;
    wide  = 1'b0;
    if (hi == 4'h8 || hi == 4'h9 || hi == 4'hB) begin
      mode = (hi == 4'h8) ? M_IMM : ((hi == 4'h9) ? M_PAGE : M_EXT);
      case (lo)
        4'h6: op = OP_LDA;
        4'h7: begin op = OP_STA; valid = (hi != 4'h8); end
        4'hB: op = OP_ADD;
        4'h9: op = OP_ADC;
        4'h4: op = OP_AND;
        4'hA: op = OP_OR;
        4'h1: op = OP_CMP;
        4'hE: begin op = OP_LDX; wide = 1'b1; valid = (hi != 4'h9); end
        default: valid = 1'b0;
      endcase
    end else begin
      case (opcode)
        8'hD7: begin op = OP_STB; mode = M_PAGE; end
        8'hCC: begin op = OP_LDD; mode = M_IMM; wide = 1'b1; end
        8'hFC: begin op = OP_LDD; mode = M_EXT; wide = 1'b1; end
        8'hFD: begin op = OP_STD; mode = M_EXT; wide = 1'b1; end
        8'h27: begin op = OP_BEQ; mode = M_IMM; end
        8'h26: begin op = OP_BNE; mode = M_IMM; end
        8'h2B: begin op = OP_BMI; mode = M_IMM; end
        8'h1F: begin op = OP_TFR; mode = M_IMM; end
        8'h7E: begin op = OP_JMP; mode = M_EXT; end
        8'h4F: op = OP_CLRA;
        8'h5F: op = OP_CLRB;
        8'h12: op = OP_NOP;
        8'h3F: op = OP_SWI;
        default: valid = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (mode)
      M_IMM:   nbytes = wide ? 2'd2 : 2'd1;
      M_PAGE:  nbytes = 2'd1;
      M_EXT:   nbytes = 2'd2;
      default: nbytes = 2'd0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_e          fn,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          n_out,
  output logic          z_out,
  output logic          c_out,
  output logic          wr_acc
);
  logic [DW:0] sum, diff;
  assign sum  = {1'b0, acc} + {1'b0, opnd} + {{DW{1'b0}}, (fn == ALU_ADC) & cin};
  assign diff = {1'b0, acc} - {1'b0, opnd};

  always_comb begin
    res   = opnd;
    c_out = cin;
    case (fn)
      ALU_ADD, ALU_ADC: begin res = sum[DW-1:0]; c_out = sum[DW]; end
      ALU_CMP:          begin res = diff[DW-1:0]; c_out = diff[DW]; end
      ALU_AND:          res = acc & opnd;
      ALU_OR:           res = acc | opnd;
      default:          res = opnd;
    endcase
  end

  assign n_out  = res[DW-1];
  assign z_out  = (res == '0);
  assign wr_acc = (fn != ALU_CMP);
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int         AW       = 16,
  parameter int         DW       = 8,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted,
  output logic          illegal
);
  localparam int WW = 2 * DW;

  cpu_state_e    state;
  logic [AW-1:0] pc;
  logic [DW-1:0] a, b, page, hi_q;
  logic [WW-1:0] x, opnd;
  logic          fn_n, fn_z, fn_c;
  logic [1:0]    cnt;
  logic          byte2;
  op_e           op_q;
  amode_e        mode_q;
  logic          wide_q;

  logic       d_valid, d_wide;
  op_e        d_op;
  amode_e     d_mode;
  logic [1:0] d_nbytes;

  acc_cpu_decode u_dec (
    .opcode(mem_rdata), .valid(d_valid), .op(d_op),
    .mode(d_mode), .wide(d_wide), .nbytes(d_nbytes)
  );

  alu_e          alu_fn;
  logic [DW-1:0] alu_m, alu_res;
  logic          alu_n, alu_z, alu_c, alu_wr;

  always_comb begin
    case (op_q)
      OP_ADD:  alu_fn = ALU_ADD;
      OP_ADC:  alu_fn = ALU_ADC;
      OP_AND:  alu_fn = ALU_AND;
      OP_OR:   alu_fn = ALU_OR;
      OP_CMP:  alu_fn = ALU_CMP;
      default: alu_fn = ALU_LD;
    endcase
  end

  assign alu_m = (state == S_MCAP) ? mem_rdata : opnd[DW-1:0];

  acc_cpu_alu #(.DW(DW)) u_alu (
    .fn(alu_fn), .acc(a), .opnd(alu_m), .cin(fn_c),
    .res(alu_res), .n_out(alu_n), .z_out(alu_z), .c_out(alu_c), .wr_acc(alu_wr)
  );

  logic          is_ctrl, is_store, commit;
  logic [WW-1:0] wide_val;
  logic [AW-1:0] ea;
  logic          take;

  assign is_ctrl  = (op_q == OP_BEQ) || (op_q == OP_BNE) || (op_q == OP_BMI) ||
                    (op_q == OP_JMP) || (op_q == OP_TFR);
  assign is_store = (op_q == OP_STA) || (op_q == OP_STB) || (op_q == OP_STD);
  assign commit   = ((state == S_EXEC) && (mode_q == M_IMM) && !is_ctrl) ||
                    ((state == S_MCAP) && !(wide_q && !byte2));
  assign wide_val = (state == S_MCAP) ? {hi_q, mem_rdata} : opnd;
  assign ea       = (mode_q == M_PAGE) ? {page, opnd[DW-1:0]} : opnd;
  assign take     = ((op_q == OP_BEQ) && fn_z) || ((op_q == OP_BNE) && !fn_z) ||
                    ((op_q == OP_BMI) && fn_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IREQ;
      pc        <= RESET_PC;
      a         <= '0;
      b         <= '0;
      x         <= '0;
      page      <= '0;
      hi_q      <= '0;
      opnd      <= '0;
      fn_n      <= 1'b0;
      fn_z      <= 1'b0;
      fn_c      <= 1'b0;
      cnt       <= '0;
      byte2     <= 1'b0;
      op_q      <= OP_NOP;
      mode_q    <= M_INH;
      wide_q    <= 1'b0;
      mem_addr  <= RESET_PC;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      halted    <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      case (state)
        S_IREQ: begin
          mem_addr <= pc;
          pc       <= pc + 16'd1;
          state    <= S_IWAIT;
        end
        S_IWAIT: state <= S_IDEC;
        S_IDEC: begin
          op_q   <= d_op;
          mode_q <= d_mode;
          wide_q <= d_wide;
          opnd   <= '0;
          if (!d_valid) begin
            halted  <= 1'b1;
            illegal <= 1'b1;
            state   <= S_HALT;
          end else if (d_nbytes == 2'd0) begin
            state <= S_IREQ;
            case (d_op)
              OP_CLRA: begin a <= '0; fn_n <= 1'b0; fn_z <= 1'b1; end
              OP_CLRB: begin b <= '0; fn_n <= 1'b0; fn_z <= 1'b1; end
              OP_SWI:  begin halted <= 1'b1; state <= S_HALT; end
              default: ;
            endcase
          end else begin
            mem_addr <= pc;
            pc       <= pc + 16'd1;
            cnt      <= d_nbytes;
            state    <= S_OWAIT;
          end
        end
        S_OWAIT: state <= S_OCAP;
        S_OCAP: begin
          opnd <= {opnd[DW-1:0], mem_rdata};
          if (cnt == 2'd2) begin
            cnt      <= 2'd1;
            mem_addr <= pc;
            pc       <= pc + 16'd1;
            state    <= S_OWAIT;
          end else begin
            state <= S_EXEC;
          end
        end
        S_EXEC: begin
          byte2 <= 1'b0;
          state <= S_IREQ;
          case (op_q)
            OP_BEQ, OP_BNE, OP_BMI:
              if (take) pc <= pc + {{DW{opnd[DW-1]}}, opnd[DW-1:0]};
            OP_JMP: pc <= opnd;
            OP_TFR:
              if (opnd[DW-1:0] == TFR_A_TO_PAGE) page <= a;
              else begin
                halted  <= 1'b1;
                illegal <= 1'b1;
                state   <= S_HALT;
              end
            default:
              if (mode_q != M_IMM) begin
                mem_addr <= ea;
                if (is_store) begin
                  mem_wdata <= (op_q == OP_STB) ? b : a;
                  mem_we    <= 1'b1;
                  state     <= (op_q == OP_STD) ? S_ST2 : S_IREQ;
                end else begin
                  state <= S_MWAIT;
                end
              end
          endcase
        end
        S_MWAIT: state <= S_MCAP;
        S_MCAP: begin
          if (wide_q && !byte2) begin
            hi_q     <= mem_rdata;
            byte2    <= 1'b1;
            mem_addr <= mem_addr + 16'd1;
            state    <= S_MWAIT;
          end else begin
            state <= S_IREQ;
          end
        end
        S_ST2: begin
          mem_addr  <= mem_addr + 16'd1;
          mem_wdata <= b;
          mem_we    <= 1'b1;
          state     <= S_IREQ;
        end
        default: state <= S_HALT;
      endcase

      if (commit) begin
        if (wide_q) begin
          if (op_q == OP_LDX) x <= wide_val;
          else begin
            a <= wide_val[WW-1:DW];
            b <= wide_val[DW-1:0];
          end
          fn_n <= wide_val[WW-1];
          fn_z <= (wide_val == '0);
        end else begin
          if (alu_wr) a <= alu_res;
          fn_n <= alu_n;
          fn_z <= alu_z;
          fn_c <= alu_c;
        end
      end
    end
  end
endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk #(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] mem_addr,
  input logic        mem_we,
  input logic        halted,
  input logic        illegal,
  input logic [15:0] x_reg,
  input logic [7:0]  a_reg
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (mem_addr == RESET_PC && !mem_we && !halted && !illegal));

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  p_halt_addr_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(mem_addr));

  p_halt_regs_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(x_reg) && $stable(a_reg)));

  p_illegal_halts_r12: assert property (@(posedge clk) disable iff (rst)
    illegal |-> halted);

  p_illegal_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);
endmodule

bind acc_cpu_core acc_cpu_core_chk #(.RESET_PC(RESET_PC)) chk_i (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
  .halted(halted), .illegal(illegal), .x_reg(x), .a_reg(a)
);

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;
  localparam int MEM_N = 1024;
  localparam int RUN_LIMIT = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, halted, illegal;
  logic [7:0]  mem [0:MEM_N-1];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  acc_cpu_core dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .illegal(illegal)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
  endtask

  task automatic load(input int base, input logic [7:0] bytes[]);
    for (int i = 0; i < bytes.size(); i++) mem[base + i] = bytes[i];
  endtask

  task automatic run(output int cyc);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (cyc < RUN_LIMIT) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (halted) break;
    end
    if (!halted) check("run limit (core never halted)", 0, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 mem_addr in reset", mem_addr, 16'h0000);
    check("R1 mem_we in reset", mem_we, 0);
    check("R1 halted in reset", halted, 0);
    check("R1 illegal in reset", illegal, 0);
  endtask

  task automatic t_timing();
    int c;
    clear_mem();
    load(0, '{8'h12, 8'h3F});
    run(c);
    check("R13 R2 NOP then SWI clocks", c, 6);
    check("R11 SWI leaves illegal low", illegal, 0);
    clear_mem();
    load(0, '{8'h86, 8'h05, 8'h3F});
    run(c);
    check("R2 immediate load then SWI clocks", c, 9);
  endtask

  task automatic t_alu();
    int c;
    clear_mem();
    load(0, '{8'h86, 8'hF0, 8'h8B, 8'h20, 8'h89, 8'h01, 8'h84, 8'h1E,
               8'h8A, 8'h80, 8'hB7, 8'h02, 8'h00,
               8'h86, 8'hFF, 8'h8B, 8'h01, 8'h89, 8'h00, 8'hB7, 8'h02, 8'h01, 8'h3F});
    run(c);
    check("R4 add/adc/and/or chain", mem[12'h200], 8'h92);
    check("R4 carry out feeds adc", mem[12'h201], 8'h01);
  endtask

  task automatic t_cmp();
    int c;
    clear_mem();
    load(0, '{8'h86, 8'h05, 8'h81, 8'h05, 8'h27, 8'h02, 8'h86, 8'h77,
               8'hB7, 8'h02, 8'h02, 8'h81, 8'h06, 8'h2B, 8'h02, 8'h86, 8'h66,
               8'h89, 8'h00, 8'hB7, 8'h02, 8'h03, 8'h3F});
    run(c);
    check("R5 R7 compare equal keeps A, BEQ taken", mem[12'h202], 8'h05);
    check("R5 R7 compare borrow sets C and N, BMI taken", mem[12'h203], 8'h06);
  endtask

  task automatic t_page();
    int c;
    clear_mem();
    load(0, '{8'h86, 8'h02, 8'h1F, 8'h8B, 8'hCC, 8'h12, 8'h34, 8'hD7, 8'h10,
               8'h96, 8'h10, 8'h9B, 8'h10, 8'hB7, 8'h02, 8'h11, 8'h97, 8'h12, 8'h3F});
    run(c);
    check("R10 R3 page store of B", mem[12'h210], 8'h34);
    check("R3 R4 page load and page add", mem[12'h211], 8'h68);
    check("R3 page store of A", mem[12'h212], 8'h68);
  endtask

  task automatic t_wide();
    int c;
    clear_mem();
    mem[12'h300] = 8'hAB;
    mem[12'h301] = 8'hCD;
    load(0, '{8'hFC, 8'h03, 8'h00, 8'hFD, 8'h03, 8'h02, 8'h8E, 8'h00, 8'h00,
               8'h27, 8'h02, 8'h86, 8'h11, 8'hBE, 8'h03, 8'h00, 8'h2B, 8'h02,
               8'h86, 8'h22, 8'hB7, 8'h03, 8'h04, 8'h3F});
    run(c);
    check("R6 pair store high byte", mem[12'h302], 8'hAB);
    check("R6 pair store low byte", mem[12'h303], 8'hCD);
    check("R6 16-bit flags (Z then N) steer branches", mem[12'h304], 8'hAB);
  endtask

  task automatic t_loop();
    int c;
    clear_mem();
    mem[12'h220] = 8'h55;
    load(0, '{8'h86, 8'h03, 8'h8B, 8'hFF, 8'h26, 8'hFC, 8'hB7, 8'h02, 8'h20, 8'h3F});
    run(c);
    check("R7 backward BNE loop result", mem[12'h220], 8'h00);
    check("R2 loop program clocks", c, 53);
  endtask

  task automatic t_jump();
    int c;
    clear_mem();
    load(0, '{8'h7E, 8'h00, 8'h10});
    load(16, '{8'h86, 8'h5A, 8'hB7, 8'h02, 8'h30, 8'h3F});
    run(c);
    check("R8 jump target executed", mem[12'h230], 8'h5A);
    check("R8 no illegal fetch", illegal, 0);
  endtask

  task automatic t_clear();
    int c;
    clear_mem();
    mem[12'h240] = 8'hFF;
    mem[12'h241] = 8'hFF;
    load(0, '{8'hCC, 8'h88, 8'h99, 8'h4F, 8'h27, 8'h02, 8'h86, 8'h44,
               8'h5F, 8'hFD, 8'h02, 8'h40, 8'h3F});
    run(c);
    check("R9 cleared A with Z=1", mem[12'h240], 8'h00);
    check("R9 cleared B", mem[12'h241], 8'h00);
  endtask

  task automatic t_illegal();
    int c;
    logic [15:0] held;
    clear_mem();
    load(0, '{8'h12, 8'h01});
    run(c);
    check("R12 illegal raised", illegal, 1);
    check("R12 halt clocks after bad opcode", c, 6);
    clear_mem();
    load(0, '{8'h86, 8'h01, 8'h1F, 8'h89, 8'h3F});
    run(c);
    check("R10 bad transfer postbyte is illegal", illegal, 1);
    clear_mem();
    mem[12'h250] = 8'h77;
    load(0, '{8'h3F, 8'hB7, 8'h02, 8'h50});
    run(c);
    held = mem_addr;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R11 no write after SWI", mem[12'h250], 8'h77);
    check("R11 address frozen after SWI", mem_addr, held);
    check("R11 halted stays high", halted, 1);
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_mem();
    t_reset();
    t_timing();
    t_alu();
    t_cmp();
    t_page();
    t_wide();
    t_loop();
    t_jump();
    t_clear();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule